// File: doc/BRIEF.md
# DMA partial-beat length handler

This block sits inside a DMA engine between a narrow streaming port and a wider memory-mapped data path. It takes a transfer request (start address, byte count minus one, direction) and cuts the transfer into memory-mapped beats. The transfer length only has to be a whole number of stream words. It does not have to be a whole number of memory beats, so a 64-bit memory side paired with a 16-bit stream side accepts any even byte count.

In the write direction, stream words are packed into a beat starting at the lowest byte lane. Every beat carries a byte-enable mask. The final beat may be partial: its unused lanes are disabled and their data is meaningless. In the read direction, every beat is fetched at full width and its words are handed out lowest lane first. The words past the transfer end are dropped silently. A configuration input forbids this over-read for targets that have read side effects, such as FIFOs. With that input set, reads must cover whole beats.

Top module: `dmaBeatSplit`

## Requirements
- R1: A request is taken when `reqValid` and `reqReady` are both high, and `reqReady` is high only while idle. A request whose byte count (`reqLenM1`+1) is not a multiple of ST_W/8 is refused: `reqErr` is high for exactly the cycle after the handshake, no data moves, and the block stays idle.
- R2: A request whose `reqAddr` is not a multiple of MM_W/8 is refused in the same way as in R1.
- R3: A write of L bytes produces exactly ceil(L/(MM_W/8)) beats on `mmW*`, and every beat except the final one has all strobe bits set.
- R4: The final write beat has `mmWLast` high and a strobe whose low (L mod MM_W/8) bits are set, with the rest clear; the strobe is all ones when that remainder is zero. Strobe bit i enables byte lane i, which is bits [8i+7:8i] of `mmWData`. `mmWLast` is low on every other beat.
- R5: In a write beat, the k-th stream word of that beat appears in bits [k*ST_W +: ST_W] of `mmWData`, with words taken in arrival order.
- R6: A read of L bytes accepts exactly ceil(L/(MM_W/8)) beats on `mmR*` and emits exactly L/(ST_W/8) words on `sOut*`. Each beat is emitted from its low lane upward. Words past the transfer end never raise `sOutValid`.
- R7: `sOutLast` is high on the final emitted word of a read and low on every other emitted word.
- R8: When `noOverRead` is high at the handshake, a read whose byte count is not a multiple of MM_W/8 is refused as in R1. Writes are not affected by `noOverRead`.
- R9: Under backpressure, `mmWValid` and `sOutValid` stay high, and their data, strobe and last outputs stay unchanged, until they are accepted. No word is lost or repeated.
- R10: After reset, and whenever idle, `reqReady` is high and `sInReady`, `mmRReady`, `mmWValid`, `sOutValid` and `reqErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| noOverRead | input | 1 | Forbid partial final read beats |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request taken |
| reqWrite | input | 1 | 1 = stream to memory, 0 = memory to stream |
| reqAddr | input | ADDR_W | Start byte address |
| reqLenM1 | input | LEN_W | Transfer byte count minus one |
| reqErr | output | 1 | One-cycle pulse on a refused request |
| sInValid | input | 1 | Write-direction stream word valid |
| sInReady | output | 1 | Write-direction stream word accepted |
| sInData | input | ST_W | Write-direction stream word |
| mmWValid | output | 1 | Write beat valid |
| mmWReady | input | 1 | Write beat accepted |
| mmWData | output | MM_W | Write beat data |
| mmWStrb | output | MM_W/8 | Write byte enables, bit i for lane i |
| mmWLast | output | 1 | Final write beat |
| mmRValid | input | 1 | Read beat valid |
| mmRReady | output | 1 | Read beat accepted |
| mmRData | input | MM_W | Read beat data |
| sOutValid | output | 1 | Read-direction stream word valid |
| sOutReady | input | 1 | Read-direction stream word accepted |
| sOutData | output | ST_W | Read-direction stream word |
| sOutLast | output | 1 | Final read word |

## Verification
Two things can fall in the same cycle: the lane counter reaching the top lane of a beat, and the word counter reaching the end of the transfer. On a write, this closes the beat and marks it final at once. On a read, it drops the held beat and ends the transfer at once. The stimulus table provokes this coincidence with lengths that are exact multiples of the beat width (8 and 16 bytes). It also includes neighbouring lengths that end mid-beat (2, 6, 18 and 22 bytes), so that the two events occur apart. The bench judges the results by the strobe and last flag of each beat or word, and by the exact count of beats and words, with nothing extra while the block sits in the idle tail.

// File: rtl/dmaBeatSplitPkg.sv
package dmaBeatSplitPkg;
  // Commands from the control FSM to the datapath, one cycle wide each.
  typedef struct packed {
    logic packWord;  // store sInData at the current lane
    logic sealBeat;  // freeze the write strobe for the beat being closed
    logic loadBeat;  // capture a whole read beat
  } dpCmd_t;
endpackage

// File: rtl/dmaBeatSplitCtrl.sv
module dmaBeatSplitCtrl
  import dmaBeatSplitPkg::*;
#(
  parameter int MM_W   = 64,
  parameter int ST_W   = 16,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  localparam int WPB    = MM_W / ST_W,
  localparam int LANE_W = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              noOverRead,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLenM1,
  output logic              reqErr,
  input  logic              sInValid,
  output logic              sInReady,
  output logic              mmWValid,
  input  logic              mmWReady,
  output logic              mmWLast,
  input  logic              mmRValid,
  output logic              mmRReady,
  output logic              sOutValid,
  input  logic              sOutReady,
  output logic              sOutLast,
  output dpCmd_t            cmd,
  output logic [LANE_W-1:0] lane
);
  localparam int MM_BYTES = MM_W / 8;
  localparam int ST_BYTES = ST_W / 8;
  localparam int ST_OFF   = $clog2(ST_BYTES);
  localparam int CNT_W    = LEN_W + 1;
  localparam logic [LEN_W-1:0]  ST_LMASK  = LEN_W'(ST_BYTES - 1);
  localparam logic [LEN_W-1:0]  MM_LMASK  = LEN_W'(MM_BYTES - 1);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(MM_BYTES - 1);
  localparam logic [LANE_W-1:0] LANE_TOP  = LANE_W'(WPB - 1);

  logic             busy, dirWr, beatHeld, lastBeat;
  logic [CNT_W-1:0] wordsLeft;
  logic             lenBad, addrBad, overBad, reqBad;
  logic [CNT_W-1:0] wordsTotal;
  logic             reqFire, sInFire, mmWFire, mmRFire, sOutFire;
  logic             finalWord, laneEnd;

  // Request screening
  always_comb begin
    lenBad     = (reqLenM1 & ST_LMASK) != ST_LMASK;
    addrBad    = (reqAddr & ADDR_MASK) != '0;
    overBad    = noOverRead && !reqWrite && ((reqLenM1 & MM_LMASK) != MM_LMASK);
    reqBad     = lenBad || addrBad || overBad;
    wordsTotal = CNT_W'(reqLenM1 >> ST_OFF) + CNT_W'(1);
  end

  assign reqReady  = !busy;
  assign sInReady  = busy && dirWr && !beatHeld;
  assign mmRReady  = busy && !dirWr && !beatHeld;
  assign mmWValid  = busy && dirWr && beatHeld;
  assign sOutValid = busy && !dirWr && beatHeld;
  assign mmWLast   = lastBeat;

  assign reqFire   = reqValid && reqReady;
  assign sInFire   = sInValid && sInReady;
  assign mmWFire   = mmWValid && mmWReady;
  assign mmRFire   = mmRValid && mmRReady;
  assign sOutFire  = sOutValid && sOutReady;
  assign finalWord = wordsLeft == CNT_W'(1);
  assign laneEnd   = lane == LANE_TOP;
  assign sOutLast  = finalWord;

  always_comb begin
    cmd          = '0;
    cmd.packWord = sInFire;
    cmd.sealBeat = sInFire && (laneEnd || finalWord);
    cmd.loadBeat = mmRFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      dirWr     <= 1'b0;
      beatHeld  <= 1'b0;
      lastBeat  <= 1'b0;
      wordsLeft <= '0;
      lane      <= '0;
      reqErr    <= 1'b0;
    end else begin
      reqErr <= 1'b0;
      if (reqFire) begin
        if (reqBad) begin
          reqErr <= 1'b1;
        end else begin
          busy      <= 1'b1;
          dirWr     <= reqWrite;
          wordsLeft <= wordsTotal;
          lane      <= '0;
          beatHeld  <= 1'b0;
          lastBeat  <= 1'b0;
        end
      end else if (busy && dirWr) begin
        if (sInFire) begin
          wordsLeft <= wordsLeft - CNT_W'(1);
          if (laneEnd || finalWord) begin
            beatHeld <= 1'b1;
            lastBeat <= finalWord;
            lane     <= '0;
          end else begin
            lane <= lane + LANE_W'(1);
          end
        end
        if (mmWFire) begin
          beatHeld <= 1'b0;
          if (lastBeat) begin
            busy     <= 1'b0;
            lastBeat <= 1'b0;
          end
        end
      end else if (busy) begin
        if (mmRFire) begin
          beatHeld <= 1'b1;
          lane     <= '0;
        end
        if (sOutFire) begin
          wordsLeft <= wordsLeft - CNT_W'(1);
          if (laneEnd || finalWord) begin
            beatHeld <= 1'b0;
            lane     <= '0;
          end else begin
            lane <= lane + LANE_W'(1);
          end
          if (finalWord) busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dmaBeatSplitDp.sv
module dmaBeatSplitDp
  import dmaBeatSplitPkg::*;
#(
  parameter int MM_W = 64,
  parameter int ST_W = 16,
  localparam int WPB      = MM_W / ST_W,
  localparam int LANE_W   = (WPB > 1) ? $clog2(WPB) : 1,
  localparam int MM_BYTES = MM_W / 8,
  localparam int ST_BYTES = ST_W / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [LANE_W-1:0]   lane,
  input  logic [ST_W-1:0]     sInData,
  input  logic [MM_W-1:0]     mmRData,
  output logic [MM_W-1:0]     mmWData,
  output logic [MM_BYTES-1:0] mmWStrb,
  output logic [ST_W-1:0]     sOutData
);
  logic [MM_W-1:0]     beatBuf;
  logic [MM_BYTES-1:0] strbReg;
  logic [MM_BYTES-1:0] sealMask;
  logic [ST_W-1:0]     laneWord [WPB];

  // Byte lanes up to and including the current word are enabled.
  for (genvar b = 0; b < MM_BYTES; b++) begin : gMask
    assign sealMask[b] = LANE_W'(b / ST_BYTES) <= lane;
  end

  for (genvar g = 0; g < WPB; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        beatBuf[g*ST_W +: ST_W] <= '0;
      end else if (cmd.loadBeat) begin
        beatBuf[g*ST_W +: ST_W] <= mmRData[g*ST_W +: ST_W];
      end else if (cmd.packWord && lane == LANE_W'(g)) begin
        beatBuf[g*ST_W +: ST_W] <= sInData;
      end
    end
    assign laneWord[g] = beatBuf[g*ST_W +: ST_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             strbReg <= '0;
    else if (cmd.sealBeat) strbReg <= sealMask;
  end

  assign mmWData  = beatBuf;
  assign mmWStrb  = strbReg;
  assign sOutData = laneWord[lane];
endmodule

// File: rtl/dmaBeatSplit.sv
module dmaBeatSplit
  import dmaBeatSplitPkg::*;
#(
  parameter int MM_W   = 64,
  parameter int ST_W   = 16,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  localparam int MM_BYTES = MM_W / 8,
  localparam int WPB      = MM_W / ST_W,
  localparam int LANE_W   = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                noOverRead,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LEN_W-1:0]    reqLenM1,
  output logic                reqErr,
  input  logic                sInValid,
  output logic                sInReady,
  input  logic [ST_W-1:0]     sInData,
  output logic                mmWValid,
  input  logic                mmWReady,
  output logic [MM_W-1:0]     mmWData,
  output logic [MM_BYTES-1:0] mmWStrb,
  output logic                mmWLast,
  input  logic                mmRValid,
  output logic                mmRReady,
  input  logic [MM_W-1:0]     mmRData,
  output logic                sOutValid,
  input  logic                sOutReady,
  output logic [ST_W-1:0]     sOutData,
  output logic                sOutLast
);
  dpCmd_t            cmd;
  logic [LANE_W-1:0] lane;

  dmaBeatSplitCtrl #(.MM_W(MM_W), .ST_W(ST_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .noOverRead(noOverRead),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLenM1(reqLenM1), .reqErr(reqErr),
    .sInValid(sInValid), .sInReady(sInReady),
    .mmWValid(mmWValid), .mmWReady(mmWReady), .mmWLast(mmWLast),
    .mmRValid(mmRValid), .mmRReady(mmRReady),
    .sOutValid(sOutValid), .sOutReady(sOutReady), .sOutLast(sOutLast),
    .cmd(cmd), .lane(lane)
  );

  dmaBeatSplitDp #(.MM_W(MM_W), .ST_W(ST_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lane(lane),
    .sInData(sInData), .mmRData(mmRData),
    .mmWData(mmWData), .mmWStrb(mmWStrb), .sOutData(sOutData)
  );
endmodule

// File: rtl/dmaBeatSplitChk.sv
module dmaBeatSplitChk #(
  parameter int MM_W = 64,
  parameter int ST_W = 16,
  localparam int MB = MM_W / 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          reqErr,
  input logic          sInReady,
  input logic          mmWValid,
  input logic          mmWReady,
  input logic [MM_W-1:0] mmWData,
  input logic [MB-1:0] mmWStrb,
  input logic          mmWLast,
  input logic          mmRReady,
  input logic          sOutValid,
  input logic          sOutReady,
  input logic [ST_W-1:0] sOutData,
  input logic          sOutLast
);
  // R1
  err_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> $past(reqValid && reqReady));
  // R1
  err_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> reqReady && !sInReady && !mmRReady);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmWValid && !mmWReady |=> mmWValid && $stable(mmWData) && $stable(mmWStrb) && $stable(mmWLast));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sOutValid && !sOutReady |=> sOutValid && $stable(sOutData) && $stable(sOutLast));
  // R3
  full_strb_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmWValid && !mmWLast |-> &mmWStrb);
  // R4
  strb_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmWValid |-> mmWStrb[0] && ((MB'(mmWStrb + 1'b1) & mmWStrb) == '0));
  // R6
  one_beat_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mmRReady && sOutValid));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !mmWValid && !sOutValid && !sInReady && !mmRReady);
endmodule

bind dmaBeatSplit dmaBeatSplitChk #(.MM_W(MM_W), .ST_W(ST_W)) uChk (.*);

// File: tb/sim_dmaBeatSplit.sv
module sim_dmaBeatSplit;
  localparam int MM_W = 64, ST_W = 16, LEN_W = 16, ADDR_W = 32;
  localparam int MB = 8, SB = 2, WPB = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic noOverRead = 0, reqValid = 0, reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLenM1 = '0;
  logic reqReady, reqErr;
  logic sInValid = 0, sInReady;
  logic [ST_W-1:0] sInData = '0;
  logic mmWValid, mmWReady = 0, mmWLast;
  logic [MM_W-1:0] mmWData;
  logic [MB-1:0] mmWStrb;
  logic mmRValid = 0, mmRReady;
  logic [MM_W-1:0] mmRData = '0;
  logic sOutValid, sOutReady = 0, sOutLast;
  logic [ST_W-1:0] sOutData;

  always #10 clk = ~clk;

  dmaBeatSplit #(.MM_W(MM_W), .ST_W(ST_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u0 (.*);

  int nChk = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ST_W-1:0] wrWord(input int i);
    return 16'(16'hA000 + i * 3);
  endfunction

  function automatic logic [MM_W-1:0] rdBeat(input int b);
    logic [MM_W-1:0] v;
    for (int k = 0; k < WPB; k++) v[k*ST_W +: ST_W] = 16'(16'h5000 + b * 16 + k);
    return v;
  endfunction

  // fields: write, noOverRead, expected error, address, length-1
  typedef struct packed {
    logic wr; logic full; logic expErr; logic [15:0] addr; logic [15:0] lenM1;
  } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 16'h0100, 16'd7},   // R3 R4 one full beat, lane end meets transfer end
    '{1'b1, 1'b0, 1'b0, 16'h0200, 16'd1},   // R4 single word, strobe 0x03
    '{1'b1, 1'b0, 1'b0, 16'h0040, 16'd21},  // R3 R4 R5 three beats, last strobe 0x3F
    '{1'b1, 1'b0, 1'b1, 16'h0000, 16'd2},   // R1 odd length refused
    '{1'b0, 1'b0, 1'b0, 16'h0008, 16'd5},   // R6 R7 three words from one beat
    '{1'b0, 1'b0, 1'b0, 16'h0010, 16'd15},  // R6 R7 two whole beats
    '{1'b0, 1'b0, 1'b0, 16'h0018, 16'd17},  // R6 R7 nine words, one kept from third beat
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'd4},   // R1 odd read length refused
    '{1'b0, 1'b1, 1'b1, 16'h0000, 16'd5},   // R8 partial read forbidden
    '{1'b0, 1'b1, 1'b0, 16'h0020, 16'd15},  // R8 whole-beat read still allowed
    '{1'b1, 1'b1, 1'b0, 16'h0028, 16'd5},   // R8 writes unaffected
    '{1'b1, 1'b0, 1'b1, 16'h0104, 16'd7}    // R2 unaligned address refused
  };

  task automatic issue(input vec_t v);
    @(negedge clk);
    reqWrite = v.wr; noOverRead = v.full; reqAddr = ADDR_W'(v.addr); reqLenM1 = v.lenM1;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqErr == v.expErr, "R1/R2/R8 reqErr after handshake", 64'(reqErr), 64'(v.expErr));
    check(reqReady == v.expErr, "R1 busy only when accepted", 64'(reqReady), 64'(v.expErr));
    if (v.expErr) begin
      @(negedge clk);
      check(reqErr == 1'b0, "R1 error lasts one cycle", 64'(reqErr), 64'd0);
      check(!sInReady && !mmRReady, "R1 no data moves after refusal", 64'({sInReady, mmRReady}), 64'd0);
    end
  endtask

  task automatic runXfer(input bit wr, input int lenBytes);
    int wordsN = lenBytes / SB;
    int beatsN = (lenBytes + MB - 1) / MB;
    int rem = lenBytes % MB;
    int sent = 0, beatsSeen = 0, fed = 0, got = 0, cyc = 0, extra = 0;
    bit done = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (wr) begin
        sInValid = (sent < wordsN) && (cyc % 5 != 4);
        sInData  = wrWord(sent);
        mmWReady = (cyc % 3 != 2);
        if (sInValid && sInReady) sent++;
        if (mmWValid && mmWReady) begin
          logic [MB-1:0] es = (beatsSeen == beatsN - 1 && rem != 0) ? MB'(8'hFF >> (MB - rem)) : '1;
          logic [MM_W-1:0] ed = '0, dm = '0;
          for (int k = 0; k < WPB; k++) begin
            if (beatsSeen * WPB + k < wordsN) begin
              ed[k*ST_W +: ST_W] = wrWord(beatsSeen * WPB + k);
              dm[k*ST_W +: ST_W] = '1;
            end
          end
          check(mmWStrb == es, "R3/R4 write strobe", 64'(mmWStrb), 64'(es));
          check(mmWLast == (beatsSeen == beatsN - 1), "R4 write last", 64'(mmWLast), 64'(beatsSeen == beatsN - 1));
          check((mmWData & dm) == ed, "R5 write lane packing", mmWData & dm, ed);
          beatsSeen++;
          done = (beatsSeen == beatsN);
        end
      end else begin
        mmRValid  = 1'b1;
        mmRData   = rdBeat(fed);
        sOutReady = (cyc % 3 != 2);
        if (mmRValid && mmRReady) fed++;
        if (sOutValid && sOutReady) begin
          logic [ST_W-1:0] ew = 16'(16'h5000 + (got / WPB) * 16 + (got % WPB));
          check(sOutData == ew, "R6 read word order", 64'(sOutData), 64'(ew));
          check(sOutLast == (got == wordsN - 1), "R7 read last flag", 64'(sOutLast), 64'(got == wordsN - 1));
          got++;
          done = (got == wordsN);
        end
      end
    end
    check(done, "R3/R6 transfer completes", 64'(cyc), 64'd2000);
    // idle tail: keep offering traffic, nothing may move
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      if (wr) begin
        sInValid = 1'b1; mmWReady = 1'b1;
        if (sInReady || mmWValid) extra++;
      end else begin
        mmRValid = 1'b1; sOutReady = 1'b1;
        if (mmRReady || sOutValid) extra++;
      end
    end
    sInValid = 0; mmWReady = 0; mmRValid = 0; sOutReady = 0;
    check(extra == 0, wr ? "R3 no extra beat or word" : "R6 no extra beat or word", 64'(extra), 64'd0);
    if (!wr) check(fed == beatsN, "R6 beats fetched", 64'(fed), 64'(beatsN));
    check(reqReady, "R10 idle after transfer", 64'(reqReady), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(reqReady && !reqErr && !mmWValid && !sOutValid && !sInReady && !mmRReady,
          "R10 reset state", 64'({reqReady, reqErr, mmWValid, sOutValid, sInReady, mmRReady}), 64'b100000);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !reqErr && !mmWValid && !sOutValid, "R10 idle after reset",
          64'({reqReady, reqErr, mmWValid, sOutValid}), 64'b1000);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      if (!VECS[i].expErr) runXfer(VECS[i].wr, int'(VECS[i].lenM1) + 1);
    end

    // R9 long stall on a write beat: data must not change or repeat
    issue('{1'b1, 1'b0, 1'b0, 16'h0000, 16'd9});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sInValid = 1'b1; sInData = wrWord(100 + k);
      while (!sInReady) @(negedge clk);
    end
    @(negedge clk); sInValid = 1'b0;
    repeat (6) @(negedge clk);
    check(mmWValid && mmWData == {wrWord(103), wrWord(102), wrWord(101), wrWord(100)},
          "R9 stalled beat held", mmWData, {wrWord(103), wrWord(102), wrWord(101), wrWord(100)});
    mmWReady = 1'b1; @(negedge clk); mmWReady = 1'b0;
    sInValid = 1'b1; sInData = wrWord(104);
    @(negedge clk); sInValid = 1'b0;
    @(negedge clk);
    check(mmWValid && mmWLast && mmWStrb == 8'h03 && mmWData[15:0] == wrWord(104),
          "R4 R9 final beat after stall", {mmWStrb, mmWData[15:0]}, {8'h03, wrWord(104)});
    mmWReady = 1'b1; @(negedge clk); mmWReady = 1'b0;
    check(reqReady, "R10 idle after stalled write", 64'(reqReady), 64'd1);

    // R10 reset in the middle of a read
    issue('{1'b0, 1'b0, 1'b0, 16'h0000, 16'd31});
    mmRValid = 1'b1; mmRData = rdBeat(0);
    @(negedge clk); mmRValid = 1'b0;
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; @(negedge clk);
    check(reqReady && !sOutValid && !mmRReady, "R10 reset aborts transfer",
          64'({reqReady, sOutValid, mmRReady}), 64'b100);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule